// File: doc/BRIEF.md
# Conversion Synchronization Controller

This block decides when a decimating converter throws away its filter history and starts a fresh conversion sequence. Two request sources feed it: a synchronization pin sampled on the master clock, and a single-cycle synchronization command. From these it produces a one-clock filter/modulator clear pulse, a modulator clock at one quarter of the master clock that is realigned on every restart, an active-low data-ready strobe once per output data period, and an enable that gates the serial data output while the filter settles.

Two modes are offered. In pulse mode every rising pin edge or accepted command restarts conversion, and the data-ready strobe is held back until settled data exists. In continuous mode a free-running sync clock may be applied. The block measures the spacing between its rising edges in master clocks and restarts only when that spacing is not a whole number of output data periods. After such a restart the data-ready strobe keeps running, and only the output enable stays low until the filter has settled. The data period (in master clocks) and the settling length (in data periods) are live inputs.

Top module: `conv_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, `filt_rst` is 0, `mod_clk` is 0, `drdy_n` is 1 and `dout_en` is 0.
- R2: In pulse mode, when `sync_pin` is sampled low at clock edge k-1 and high at edge k, a restart takes effect at edge r = k+1: `filt_rst` is high for exactly the clock period after edge r.
- R3: `mod_clk` is low from edge r up to edge r+4 and rises at edge r+4, five edges after the sampling edge k. It then repeats with a period of 4 clocks, high for 2 and low for 2, until the next restart. After reset release it behaves as if r were the last edge before the first active edge.
- R4: With `data_period` = D (D >= 2), an output tick n (n >= 1) occurs at edge r+n*D. A visible tick drives `drdy_n` low for exactly one clock period after that edge.
- R5: In pulse mode, with Sm = max(`settle_count`, 1), ticks with n < Sm are not visible (`drdy_n` stays high). `dout_en` rises at edge r+Sm*D and stays high until the next restart.
- R6: A `sync_cmd` that is high at edge k restarts with the same timing as R2, but only if `sync_pin` is also high at edge k. With the pin low the command has no effect.
- R7: In continuous mode (`cont_mode` = 1), the first rising pin edge after reset always restarts.
- R8: In continuous mode, a rising pin edge whose spacing from the previous rising edge is a multiple of D master clocks causes no restart, whatever its phase relative to `drdy_n`.
- R9: In continuous mode, a rising pin edge whose spacing is not a multiple of D restarts. After that restart, every tick n >= 1 is visible on `drdy_n`, while `dout_en` stays low until edge r+Sm*D.
- R10: In pulse mode, every rising pin edge restarts, even when its spacing is a multiple of D.
- R11: A pin held high causes only one restart; restarts are triggered by edges, not by level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Synchronization pin or sync clock |
| sync_cmd | input | 1 | One-cycle synchronization command |
| cont_mode | input | 1 | 0 = pulse mode, 1 = continuous mode |
| data_period | input | PERIOD_W | Output data period in master clocks (>= 2) |
| settle_count | input | SETTLE_W | Data periods until settled output |
| filt_rst | output | 1 | One-clock clear for filter and modulator state |
| mod_clk | output | 1 | Modulator clock, master clock divided by 4 |
| drdy_n | output | 1 | Active-low one-clock data-ready strobe |
| dout_en | output | 1 | High when output data is valid; gates DOUT low otherwise |

## Verification
Pulse mode is swept over several data periods and settling lengths, with pin edges spaced at, above and below multiples of the period. This separates edge-triggered restarts from period-matched ones and shows whether the strobe is held back for the right number of ticks. A pin held high and commands with the pin high and low distinguish edge from level triggering and show the command gating. Continuous mode receives a first edge, single edges at matching spacings, then mismatched spacings and a free-running sync clock with matching and non-matching periods. These patterns show whether a restart happens, and whether the strobe keeps running while the output enable waits. Every cycle's four outputs are compared with values derived from the most recent restart edge.

// File: rtl/csc_pkg.sv
// Package: shared types for the conversion synchronization controller.
// Assumes nothing beyond IEEE 1800-2017.
package csc_pkg;

    // Operating mode of the restart logic.
    typedef enum logic {
        SYNC_PULSE = 1'b0,
        SYNC_CONT  = 1'b1
    } sync_mode_e;

    // Fixed modulator clock division (master clocks per modulator clock).
    localparam int unsigned MOD_DIV = 4;

endpackage

// File: rtl/csc_sync_sampler.sv
// Samples the sync pin and sync command on the master clock.
// Provides a one-cycle rising-edge flag of the pin and a command hit that
// is only valid when the pin was high at the same sampling edge.
// Assumes sync_pin is already synchronous to clk or metastability is handled upstream.
module csc_sync_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    input  logic sync_cmd,
    output logic pin_rise,
    output logic cmd_hit
);

    logic pin_q;
    logic pin_d;
    logic cmd_q;

    // Capture pin, its previous value and the gated command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            pin_d <= 1'b0;
            cmd_q <= 1'b0;
        end else begin
            pin_q <= sync_pin;
            pin_d <= pin_q;
            cmd_q <= sync_cmd & sync_pin;
        end
    end

    // Edge and command flags for the cycle after the sampling edge.
    always_comb begin
        pin_rise = pin_q & ~pin_d;
        cmd_hit  = cmd_q;
    end

endmodule

// File: rtl/csc_period_check.sv
// Decides whether a rising sync edge must restart conversion.
// Pulse mode: every edge restarts. Continuous mode: the first edge restarts,
// later edges restart only when the edge spacing is not a multiple of the
// data period. Spacing is tracked as a phase that wraps at the data period,
// so no divider is needed. Assumes data_period >= 2.
module csc_period_check
    import csc_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sync_mode_e          mode,
    input  logic                pin_rise,
    input  logic [PERIOD_W-1:0] data_period,
    output logic                resync_req
);

    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] phase;
    logic [PERIOD_W-1:0] last_idx;
    logic                armed;

    // Highest phase value before wrapping.
    always_comb last_idx = data_period - ONE;

    // Phase of the elapsed spacing and the first-edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            armed <= 1'b0;
        end else begin
            if (mode != SYNC_CONT) begin
                armed <= 1'b0;
            end else if (pin_rise) begin
                armed <= 1'b1;
            end
            if (pin_rise) begin
                phase <= (data_period <= ONE) ? '0 : ONE;
            end else if (phase >= last_idx) begin
                phase <= '0;
            end else begin
                phase <= phase + ONE;
            end
        end
    end

    // Restart request from the pin path.
    always_comb begin
        if (mode == SYNC_CONT) begin
            resync_req = pin_rise & (~armed | (phase != '0));
        end else begin
            resync_req = pin_rise;
        end
    end

endmodule

// File: rtl/csc_modclk_gen.sv
// Generates the modulator clock at one quarter of the master clock.
// On restart the output is forced low and held quiet so that its next
// rising edge comes four edges after the restart edge (five after sampling).
// Assumes restart is a registered-domain pulse of one or more cycles.
module csc_modclk_gen
    import csc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic mod_clk
);

    localparam int unsigned PH_W = $clog2(MOD_DIV);
    localparam logic [PH_W-1:0] PH_LOAD = PH_W'(MOD_DIV / 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MOD_DIV - 1);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_n;
    logic            quiet;
    logic            quiet_n;
    logic            mclk_q;

    // Next phase and quiet state.
    always_comb begin
        if (restart) begin
            ph_n    = PH_LOAD;
            quiet_n = 1'b1;
        end else begin
            ph_n    = ph + PH_W'(1);
            quiet_n = quiet & (ph != PH_LAST);
        end
    end

    // Phase counter, quiet flag and registered clock output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_LOAD;
            quiet  <= 1'b1;
            mclk_q <= 1'b0;
        end else begin
            ph     <= ph_n;
            quiet  <= quiet_n;
            mclk_q <= ph_n[PH_W-1] & ~quiet_n;
        end
    end

    always_comb mod_clk = mclk_q;

endmodule

// File: rtl/csc_frame_timer.sv
// Counts master clocks into output data periods and settling periods.
// Emits a one-clock active-low data-ready strobe per period, suppressed in
// pulse mode until settled, and an output enable raised once settled.
// Assumes data_period >= 2; settle_count of 0 acts as 1.
module csc_frame_timer
    import csc_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  sync_mode_e          mode,
    input  logic [PERIOD_W-1:0] data_period,
    input  logic [SETTLE_W-1:0] settle_count,
    output logic                drdy_n,
    output logic                dout_en
);

    localparam logic [SETTLE_W-1:0] SET_MAX = {SETTLE_W{1'b1}};

    logic [PERIOD_W-1:0] frame_cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                tick;
    logic                done_now;
    logic                drdy_q;
    logic                valid_q;

    // Period boundary and settling decision for the current cycle.
    always_comb begin
        tick     = ~restart & (frame_cnt >= (data_period - PERIOD_W'(1)));
        done_now = valid_q |
                   (({1'b0, settle_cnt} + (SETTLE_W+1)'(1)) >= {1'b0, settle_count});
    end

    // Clock counter within one data period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            frame_cnt <= '0;
        end else if (tick) begin
            frame_cnt <= '0;
        end else begin
            frame_cnt <= frame_cnt + PERIOD_W'(1);
        end
    end

    // Saturating count of periods since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            settle_cnt <= '0;
        end else if (tick && settle_cnt != SET_MAX) begin
            settle_cnt <= settle_cnt + SETTLE_W'(1);
        end
    end

    // Strobe and output enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_q  <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            drdy_q <= ~(tick & ((mode == SYNC_CONT) | done_now));
            if (restart) begin
                valid_q <= 1'b0;
            end else if (tick && done_now) begin
                valid_q <= 1'b1;
            end
        end
    end

    always_comb begin
        drdy_n  = drdy_q;
        dout_en = valid_q;
    end

endmodule

// File: rtl/conv_sync_ctrl.sv
// Conversion synchronization controller top.
// Merges pin and command restart requests, drives the filter clear pulse,
// the modulator clock, the data-ready strobe and the output enable.
// Assumes data_period >= 2 and configuration changes only around a restart.
module conv_sync_ctrl
    import csc_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_pin,
    input  logic                sync_cmd,
    input  logic                cont_mode,
    input  logic [PERIOD_W-1:0] data_period,
    input  logic [SETTLE_W-1:0] settle_count,
    output logic                filt_rst,
    output logic                mod_clk,
    output logic                drdy_n,
    output logic                dout_en
);

    sync_mode_e mode;
    logic       pin_rise;
    logic       cmd_hit;
    logic       resync_req;
    logic       restart;
    logic       filt_rst_q;

    // Mode decode from the plain input bit.
    always_comb mode = cont_mode ? SYNC_CONT : SYNC_PULSE;

    csc_sync_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pin (sync_pin),
        .sync_cmd (sync_cmd),
        .pin_rise (pin_rise),
        .cmd_hit  (cmd_hit)
    );

    csc_period_check #(
        .PERIOD_W (PERIOD_W)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .pin_rise    (pin_rise),
        .data_period (data_period),
        .resync_req  (resync_req)
    );

    // Any accepted request restarts at the next edge.
    always_comb restart = resync_req | cmd_hit;

    // One-clock filter and modulator clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_rst_q <= 1'b0;
        end else begin
            filt_rst_q <= restart;
        end
    end

    always_comb filt_rst = filt_rst_q;

    csc_modclk_gen u_modclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .mod_clk (mod_clk)
    );

    csc_frame_timer #(
        .PERIOD_W (PERIOD_W),
        .SETTLE_W (SETTLE_W)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .mode         (mode),
        .data_period  (data_period),
        .settle_count (settle_count),
        .drdy_n       (drdy_n),
        .dout_en      (dout_en)
    );

endmodule

// File: rtl/conv_sync_ctrl_chk.sv
// Checker for conv_sync_ctrl: temporal properties on the top-level ports.
// Assumes data_period >= 2 while running.
module conv_sync_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cont_mode,
    input logic filt_rst,
    input logic mod_clk,
    input logic drdy_n,
    input logic dout_en
);

    // R9: a restart always drops the output enable.
    p_clear_drops_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |-> !dout_en);

    // R3: modulator clock is quiet in the cycle of the clear pulse.
    p_modclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |-> !mod_clk);

    // R3: a modulator clock high phase lasts two clocks unless restarted.
    p_modclk_high_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_clk) |=> (mod_clk || filt_rst));

    // R5: in pulse mode a visible strobe implies settled output.
    p_pulse_strobe_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_mode && !drdy_n) |-> dout_en);

    // R4: the data-ready strobe lasts one clock.
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |=> drdy_n);

endmodule

bind conv_sync_ctrl conv_sync_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cont_mode (cont_mode),
    .filt_rst  (filt_rst),
    .mod_clk   (mod_clk),
    .drdy_n    (drdy_n),
    .dout_en   (dout_en)
);

// File: tb/conv_sync_ctrl_test.sv
// Bench for conv_sync_ctrl: cycle model driven by the last restart edge.
module conv_sync_ctrl_test;

    localparam int PW = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_pin = 1'b0;
    logic          sync_cmd = 1'b0;
    logic          cont_mode = 1'b0;
    logic [PW-1:0] data_period = PW'(4);
    logic [SW-1:0] settle_count = '0;
    logic          filt_rst;
    logic          mod_clk;
    logic          drdy_n;
    logic          dout_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state
    int    c = 0;
    int    rs = 0;
    int    pend = 0;
    bit    pend_v = 0;
    int    last_rise = 0;
    bit    armed = 0;
    bit    prev_pin = 0;
    int    d_cfg = 4;
    int    s_min = 1;
    bit    cont = 0;
    string scen = "R1";

    always #2 clk = ~clk;

    conv_sync_ctrl #(.PERIOD_W(PW), .SETTLE_W(SW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_pin     (sync_pin),
        .sync_cmd     (sync_cmd),
        .cont_mode    (cont_mode),
        .data_period  (data_period),
        .settle_count (settle_count),
        .filt_rst     (filt_rst),
        .mod_clk      (mod_clk),
        .drdy_n       (drdy_n),
        .dout_en      (dout_en)
    );

    task automatic chk(input string req, input string sig, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s [%s] edge %0d: actual=%0b expected=%0b",
                     req, sig, scen, c, act, exp);
        end
    endtask

    // Hold reset, load configuration, release; checks R1 during reset.
    task automatic reconfig(input int d, input int s, input bit cm);
        rst_n = 1'b0;
        sync_pin = 1'b0;
        sync_cmd = 1'b0;
        cont_mode = cm;
        data_period = PW'(d);
        settle_count = SW'(s);
        d_cfg = d;
        s_min = (s < 1) ? 1 : s;
        cont = cm;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            c++;
            @(negedge clk);
            chk("R1", "filt_rst", filt_rst, 1'b0);
            chk("R1", "mod_clk", mod_clk, 1'b0);
            chk("R1", "drdy_n", drdy_n, 1'b1);
            chk("R1", "dout_en", dout_en, 1'b0);
        end
        rst_n = 1'b1;
        rs = c;
        prev_pin = 0;
        armed = 0;
        pend_v = 0;
    endtask

    // One clock with given pin and command; updates model and checks outputs.
    task automatic cyc(input logic pin, input logic cmd);
        bit rise;
        bit ev;
        int u;
        bit e_low;
        sync_pin = pin;
        sync_cmd = cmd;
        @(posedge clk);
        c++;
        if (pend_v && pend == c) begin
            rs = c;
            pend_v = 0;
        end
        ev = 0;
        rise = pin && !prev_pin;
        prev_pin = pin;
        if (rise) begin
            if (!cont) begin
                ev = 1;
            end else begin
                if (!armed || ((c - last_rise) % d_cfg) != 0) ev = 1;
                armed = 1;
                last_rise = c;
            end
        end
        if (cmd && pin) ev = 1;
        if (ev) begin
            pend = c + 1;
            pend_v = 1;
        end
        @(negedge clk);
        u = c - rs;
        e_low = (u > 0) && ((u % d_cfg) == 0) && (cont || (u / d_cfg) >= s_min);
        chk(cont ? "R8" : "R2", "filt_rst", filt_rst, (u == 0));
        chk("R3", "mod_clk", mod_clk, (u >= 4) && (((u - 4) % 4) < 2));
        chk("R4", "drdy_n", drdy_n, !e_low);
        chk(cont ? "R9" : "R5", "dout_en", dout_en, (u >= s_min * d_cfg));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    // One rising edge, next rising edge g clocks later.
    task automatic pin_gap(input int g);
        cyc(1'b1, 1'b0);
        for (int i = 1; i < g; i++) cyc(1'b0, 1'b0);
    endtask

    // Free-running sync clock with given half period.
    task automatic sync_clock(input int half, input int n);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < half; i++) cyc(1'b1, 1'b0);
            for (int i = 0; i < half; i++) cyc(1'b0, 1'b0);
        end
    endtask

    initial begin
        @(negedge clk);
        scen = "R1";
        reconfig(4, 2, 1'b0);
        idle(30);

        // Pulse mode sweep: R10 plus settling R5
        for (int d = 4; d <= 6; d++) begin
            for (int s = 0; s <= 3; s++) begin
                scen = "R10";
                reconfig(d, s, 1'b0);
                idle(3);
                pin_gap(2 * d);
                pin_gap(d);
                pin_gap(d + 1);
                pin_gap(3);
                idle(5 * d + 4);
            end
        end

        // Held pin: R11; command gating: R6
        scen = "R11";
        reconfig(5, 1, 1'b0);
        idle(2);
        for (int i = 0; i < 25; i++) cyc(1'b1, 1'b0);
        scen = "R6";
        cyc(1'b1, 1'b1);
        for (int i = 0; i < 14; i++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        idle(14);
        cyc(1'b1, 1'b1);
        idle(14);

        // Continuous mode sweep: R7, R8, R9
        for (int di = 0; di < 3; di++) begin
            for (int s = 1; s <= 3; s++) begin
                int d;
                d = (di == 0) ? 4 : ((di == 1) ? 5 : 7);
                scen = "R7";
                reconfig(d, s, 1'b1);
                idle(d + 3);
                pin_gap(2 * d);
                scen = "R8";
                pin_gap(d);
                pin_gap(3 * d);
                pin_gap(2 * d + 3);
                scen = "R9";
                pin_gap(d + 2);
                pin_gap(2 * d);
                idle((s + 1) * d);
                scen = "R8";
                sync_clock(d, 4);
                scen = "R9";
                sync_clock(3, 3);
                scen = "R6";
                cyc(1'b1, 1'b1);
                idle((s + 1) * d + 4);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule